// File: doc/BRIEF.md
# Immediate-Shift Operand Barrel Shifter

This block forms the second operand of a processor datapath from a register value and an immediate shift field. It takes a data word, a two-bit shift kind (logical left, logical right, arithmetic right, rotate right), a field holding the shift amount and the current carry flag. It returns the shifted word and a shifter carry-out, which the downstream ALU may use to update its flags. The result and carry-out are registered, so they appear one clock after the inputs.

An all-zero amount field does not always mean "no shift". For a logical left shift it passes the word through and hands the incoming carry flag on unchanged. For the logical and arithmetic right shifts it selects a shift by the full word width, an amount the field cannot otherwise hold. For rotate it selects a one-place rotate through the carry flag: the carry flag enters the top bit and the old bit 0 leaves as the carry-out. A single right-shifting log-stage barrel handles every kind. Left shifts run through it with the bit order reversed.

Top module: `opnd_shifter`

## Requirements
- R1: Result and carry-out are registered with one clock of latency. A synchronous active-high reset clears both to zero.
- R2: The shift kind is encoded as 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right and 2'b11 rotate right.
- R3: A logical left shift with field 0 returns the input word unchanged, and the carry-out equals the carry-in.
- R4: A logical left shift by n (1 to W-1) returns the input shifted left by n with zeros entering at bit 0. The carry-out is input bit W-n.
- R5: A logical right shift by n (1 to W-1) fills from the top with zeros, and the carry-out is input bit n-1.
- R6: A logical right shift with field 0 shifts by W. The result is all zeros and the carry-out is input bit W-1.
- R7: An arithmetic right shift by n (1 to W-1) fills from the top with copies of input bit W-1, and the carry-out is input bit n-1.
- R8: An arithmetic right shift with field 0 shifts by W. Every result bit and the carry-out equal input bit W-1.
- R9: A rotate right by n (1 to W-1) returns the input rotated right by n, and the carry-out equals result bit W-1.
- R10: A rotate right with field 0 returns {carry-in, input[W-1:1]}, and the carry-out is input bit 0.
- R11: The carry-in has no effect on the result or the carry-out, except in the R3 and R10 cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Word to be shifted |
| kind | input | 2 | Shift kind (R2 encoding) |
| fld | input | $clog2(W) | Immediate shift amount field |
| cin | input | 1 | Current carry flag |
| dout | output | W | Registered shifted operand |
| cout | output | 1 | Registered shifter carry-out |

## Verification
The bench sweeps all four kinds, every field value and both carry-in levels. It uses sign-heavy words, single-bit words and random words, and compares against a 64-bit arithmetic model. The zero field is the main target, because it means something different for each kind. A design that treated it as a plain zero shift would return the input for the right shifts instead of zeros or sign copies, and would give a wrong carry. A design that got the rotate-through-carry wrong would drop the carry-in from bit W-1 or report the wrong carry-out bit. Running every field value under both carry-in levels exposes any carry-in that leaks into ordinary shifts. It also exposes off-by-one carry bit selection at amounts 1 and W-1.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;
  // Shift kind encoding (R2)
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/opnd_shift_ctl.sv
// Turns kind + immediate field into barrel controls.
module opnd_shift_ctl
  import opnd_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = $clog2(W),
  parameter int AW = FW + 1
) (
  input  logic [1:0]    kind,
  input  logic [FW-1:0] fld,
  input  logic          sign_bit,
  input  logic          cin,
  output logic [AW-1:0] amt,
  output logic          fill,
  output logic          upper_data,
  output logic          rev
);
  logic fld_zero;
  assign fld_zero = (fld == '0);

  always_comb begin
    amt        = AW'(fld);
    fill       = 1'b0;
    upper_data = 1'b0;
    rev        = 1'b0;
    unique case (shift_kind_e'(kind))
      SK_LSL: begin
        rev = 1'b1;                        // left shift via reversed right shift
      end
      SK_LSR: begin
        if (fld_zero) amt = AW'(W);        // zero field means full width
      end
      SK_ASR: begin
        fill = sign_bit;
        if (fld_zero) amt = AW'(W);
      end
      SK_ROR: begin
        if (fld_zero) begin
          amt  = AW'(1);                   // rotate through carry by one
          fill = cin;
        end else begin
          upper_data = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_shift_barrel.sv
// Log-stage right shifter over a widened vector.
module opnd_shift_barrel #(
  parameter int VW = 65,
  parameter int AW = 6
) (
  input  logic [VW-1:0] vin,
  input  logic          fill,
  input  logic [AW-1:0] amt,
  output logic [VW-1:0] vout
);
  logic [VW-1:0] stg [AW+1];
  assign stg[0] = vin;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign stg[i+1] = amt[i] ? {{S{fill}}, stg[i][VW-1:S]} : stg[i];
  end

  assign vout = stg[AW];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter  int W  = 32,
  localparam int FW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [FW-1:0] fld,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  localparam int AW = FW + 1;
  localparam int VW = 2 * W + 1;

  logic [AW-1:0] amt;
  logic          fill, upper_data, rev;

  opnd_shift_ctl #(.W(W), .FW(FW), .AW(AW)) ctl_i (
    .kind(kind), .fld(fld), .sign_bit(din[W-1]), .cin(cin),
    .amt(amt), .fill(fill), .upper_data(upper_data), .rev(rev)
  );

  logic [W-1:0] din_rev, data_in, upper, res_raw, res_rev, res;
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign din_rev[b] = din[W-1-b];
    assign res_rev[b] = res_raw[W-1-b];
  end

  assign data_in = rev ? din_rev : din;
  assign upper   = upper_data ? data_in : {W{fill}};

  // The guard bit below the data becomes the carry when nothing is shifted out.
  logic [VW-1:0] vin, vout;
  assign vin = {upper, data_in, cin};

  opnd_shift_barrel #(.VW(VW), .AW(AW)) barrel_i (
    .vin(vin), .fill(fill), .amt(amt), .vout(vout)
  );

  assign res_raw = vout[W:1];
  assign res     = rev ? res_rev : res_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      cout <= 1'b0;
    end else begin
      dout <= res;
      cout <= vout[0];
    end
  end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk
  import opnd_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  din,
  input logic [1:0]    kind,
  input logic [FW-1:0] fld,
  input logic          cin,
  input logic [W-1:0]  dout,
  input logic          cout
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dout == '0 && !cout));

  a_r3_lsl_zero_passes: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_LSL && $past(fld) == '0)
      |-> (dout == $past(din) && cout == $past(cin)));

  a_r4_lsl_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_LSL && $past(fld) != '0) |-> !dout[0]);

  a_r6_lsr_full_clear: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_LSR && $past(fld) == '0)
      |-> (dout == '0 && cout == $past(din[W-1])));

  a_r7_asr_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_ASR) |-> dout[W-1] == $past(din[W-1]));

  a_r8_asr_full_sign: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_ASR && $past(fld) == '0)
      |-> (dout == {W{$past(din[W-1])}} && cout == $past(din[W-1])));

  a_r9_ror_carry_msb: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_ROR && $past(fld) != '0) |-> cout == dout[W-1]);

  a_r10_rrx: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(kind) == SK_ROR && $past(fld) == '0)
      |-> (dout == {$past(cin), $past(din[W-1:1])} && cout == $past(din[0])));
endmodule

bind opnd_shifter opnd_shifter_chk #(.W(W), .FW(FW)) chk_i (
  .clk(clk), .rst(rst), .din(din), .kind(kind), .fld(fld), .cin(cin),
  .dout(dout), .cout(cout)
);

// File: tb/opnd_shifter_tb_top.sv
`timescale 1ns/1ps
module opnd_shifter_tb_top;
  localparam int W = 32;
  localparam int FW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [1:0]    kind = '0;
  logic [FW-1:0] fld = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  dout;
  logic          cout;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  opnd_shifter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .din(din), .kind(kind), .fld(fld), .cin(cin),
    .dout(dout), .cout(cout)
  );

  // Reference model built on 64-bit arithmetic (R2 encoding: 0 LSL,1 LSR,2 ASR,3 ROR)
  task automatic model(input logic [31:0] d, input int k, input int f, input logic c,
                       output logic [31:0] r, output logic co);
    logic [63:0] t;
    int n;
    case (k)
      0: begin
        if (f == 0) begin r = d; co = c; end
        else begin t = {32'b0, d} << f; r = t[31:0]; co = t[32]; end
      end
      1: begin
        n = (f == 0) ? 32 : f;
        t = {d, 32'b0} >> n; r = t[63:32]; co = t[31];
      end
      2: begin
        n = (f == 0) ? 32 : f;
        t = $signed({d, 32'b0}) >>> n; r = t[63:32]; co = t[31];
      end
      default: begin
        if (f == 0) begin r = {c, d[31:1]}; co = d[0]; end
        else begin t = {d, d} >> f; r = t[31:0]; co = r[31]; end
      end
    endcase
  endtask

  function automatic string tag_of(input int k, input int f, input logic c);
    string base;
    bit special;
    case (k)
      0: base = (f == 0) ? "R3" : "R4";
      1: base = (f == 0) ? "R6" : "R5";
      2: base = (f == 0) ? "R8" : "R7";
      default: base = (f == 0) ? "R10" : "R9";
    endcase
    special = (f == 0) && (k == 0 || k == 3);
    return $sformatf("%s/R2%s", base, (c && !special) ? "/R11" : "");
  endfunction

  task automatic run_one(input logic [31:0] d, input int k, input int f, input logic c);
    logic [31:0] er;
    logic        ec;
    string       tg;
    din = d; kind = 2'(k); fld = 5'(f); cin = c;
    @(negedge clk);
    model(d, k, f, c, er, ec);
    tg = tag_of(k, f, c);
    total++;
    if (dout !== er || cout !== ec) begin
      bad++;
      $display("FAIL %s: kind=%0d fld=%0d cin=%0b din=%h got=%h/%b exp=%h/%b",
               tg, k, f, c, d, dout, cout, er, ec);
    end
  endtask

  logic [31:0] ops [16];

  initial begin
    ops[0] = 32'h0000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h8000_0000;
    ops[3] = 32'h0000_0001; ops[4] = 32'h7FFF_FFFF; ops[5] = 32'hA5A5_A5A5;
    ops[6] = 32'h5A5A_5A5A; ops[7] = 32'h8000_0001;
    for (int i = 8; i < 16; i++) ops[i] = $urandom;

    // R1: reset state
    rst = 1'b1; din = '1; cin = 1'b1; kind = 2'd3;
    repeat (3) @(negedge clk);
    total++;
    if (dout !== '0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset got=%h/%b exp=%h/%b", dout, cout, 32'h0, 1'b0);
    end
    rst = 1'b0;

    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 4; k++)
        for (int f = 0; f < 32; f++)
          for (int c = 0; c < 2; c++)
            run_one(ops[o], k, f, c[0]);

    // R1: reset in mid-stream clears registered outputs
    din = 32'hFFFF_FFFF; kind = 2'd2; fld = 5'd0; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    total++;
    if (dout !== '0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1: mid reset got=%h/%b exp=%h/%b", dout, cout, 32'h0, 1'b0);
    end
    rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule